// File: doc/BRIEF.md
# Inline Memory Upload Engine

This block sits behind a command processor that issues a stream of 32-bit method writes, each carrying a word offset, a 32-bit argument and a flag that marks the last method of a burst. A few configuration methods set the length of one line in bytes, the number of lines and a 64-bit destination address. An arm method then fixes the transfer size as line length times line count, and a run of payload methods fills an internal buffer four bytes at a time.

When a payload method carrying the last-call flag arrives, the engine drains the buffer to memory as 32-bit beats with byte enables, one beat per cycle at consecutive word addresses, and then pulses a completion flag that tells the rest of the chip that memory has changed. Only linear destinations are handled. An arm that asks for a tiled layout, or for more bytes than the buffer holds, is refused and reported through an error flag.

Top module: `inline_upload_engine`

## Requirements
- R1: After reset `busy`, `mem_wr_valid`, `upload_done`, `err_unsupported` and `err_overflow` are all 0.
- R2: Methods are decoded by word offset: 0x060 line length, 0x061 line count, 0x062 destination address bits 63:32, 0x063 destination address bits 31:0, 0x06C arm (argument bit 0 = 1 selects a linear destination), 0x06D payload; every other offset has no effect.
- R3: An accepted arm sets the transfer size to line length × line count, restarts the fill position at byte 0, captures the destination address, and raises `busy` from the next cycle; an arm that arrives while the buffer is being drained is ignored.
- R4: Each payload method while armed supplies min(4, size − fill position) bytes, taken from the argument in little-endian order (bits 7:0 go to the lowest address), and the fill position advances by that count.
- R5: A payload method with the last-call flag starts the drain in the next cycle: beat i carries address destination + 4·i and buffer word i, with one beat in every cycle and ceil(size/4) beats in total.
- R6: Every drain beat has byte enable 4'b1111 except a final partial word, which enables only its low size mod 4 bytes (4'b0001, 4'b0011 or 4'b0111).
- R7: `upload_done` is high for exactly one cycle, the cycle after the final beat, and `busy` falls in that same cycle.
- R8: An arm with bit 0 = 0 sets `err_unsupported`, leaves the engine idle and causes no memory write.
- R9: An arm whose size (full 64-bit product) exceeds BUF_BYTES sets `err_overflow` and is refused; a size equal to BUF_BYTES is accepted. Both error flags are recomputed at every arm that is not ignored.
- R10: Payload methods that arrive while nothing is armed, including ones flagged last call, cause no write, no completion pulse and leave `busy` low.
- R11: A zero-byte transfer completes with a single `upload_done` pulse in the cycle after the last-call payload and no memory beat.
- R12: Payload methods beyond the transfer size leave the buffered bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mthd_valid | input | 1 | A method write is present this cycle |
| mthd_addr | input | MADDR_W | Method word offset |
| mthd_data | input | 32 | Method argument |
| mthd_last | input | 1 | Method is the last call of its burst |
| mem_wr_valid | output | 1 | Memory write beat valid |
| mem_wr_addr | output | 64 | Byte address of the beat (word aligned) |
| mem_wr_data | output | 32 | Beat data, byte 0 in bits 7:0 |
| mem_wr_be | output | 4 | Byte enables of the beat |
| busy | output | 1 | Transfer armed or draining |
| upload_done | output | 1 | One-cycle memory-written notification |
| err_unsupported | output | 1 | Last arm asked for a non-linear destination |
| err_overflow | output | 1 | Last arm exceeded the buffer capacity |

## Verification
A wrong fill position shows up only at the drain, as a beat whose data lands in the wrong word or whose final byte enables are too wide or too narrow, so each test compares every beat's address, data and mask against a model built from the sent payload. A stuck or skipped state shows within one cycle as `busy` staying high, a drain that starts late, a missing or doubled `upload_done`, or beats appearing after a refused arm or idle payload. Sizes at the buffer limit and beyond, a 64-bit product that would wrap in 32 bits, and every tail length mod 4 are exercised directly.

// File: rtl/iue_pkg.sv
package iue_pkg;

  localparam logic [11:0] OFS_LINE_LEN = 12'h060;
  localparam logic [11:0] OFS_LINE_CNT = 12'h061;
  localparam logic [11:0] OFS_DEST_HI  = 12'h062;
  localparam logic [11:0] OFS_DEST_LO  = 12'h063;
  localparam logic [11:0] OFS_ARM      = 12'h06C;
  localparam logic [11:0] OFS_PAYLOAD  = 12'h06D;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_DRAIN = 2'd2
  } iue_state_e;

  // Bytes a payload word contributes at a given fill position.
  function automatic int unsigned step_bytes(int unsigned size, int unsigned pos);
    if (pos >= size) return 0;
    else if (size - pos >= 4) return 4;
    else return size - pos;
  endfunction

  // Number of 32-bit beats needed to drain a buffer of the given size.
  function automatic int unsigned beat_count(int unsigned size);
    return (size + 3) / 4;
  endfunction

  // Byte enables of the last beat.
  function automatic logic [3:0] tail_mask(int unsigned size);
    case (size % 4)
      1:       return 4'b0001;
      2:       return 4'b0011;
      3:       return 4'b0111;
      default: return 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/iue_decode.sv
module iue_decode
  import iue_pkg::*;
#(
  parameter int MADDR_W = 12,
  parameter int CNT_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mthd_valid,
  input  logic [MADDR_W-1:0] mthd_addr,
  input  logic [31:0]        mthd_data,
  input  logic               mthd_last,
  output logic [CNT_W-1:0]   line_len,
  output logic [CNT_W-1:0]   line_cnt,
  output logic [63:0]        dest_addr,
  output logic               arm_hit,
  output logic               arm_linear,
  output logic               pay_hit,
  output logic               pay_last,
  output logic [31:0]        pay_word
);

  logic [31:0] dest_hi_q, dest_lo_q;

  function automatic logic hit(logic [MADDR_W-1:0] a, logic [11:0] ofs);
    return a == MADDR_W'(ofs);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_len  <= '0;
      line_cnt  <= '0;
      dest_hi_q <= '0;
      dest_lo_q <= '0;
    end else if (mthd_valid) begin
      if (hit(mthd_addr, OFS_LINE_LEN)) line_len  <= CNT_W'(mthd_data);
      if (hit(mthd_addr, OFS_LINE_CNT)) line_cnt  <= CNT_W'(mthd_data);
      if (hit(mthd_addr, OFS_DEST_HI))  dest_hi_q <= mthd_data;
      if (hit(mthd_addr, OFS_DEST_LO))  dest_lo_q <= mthd_data;
    end
  end

  assign dest_addr  = {dest_hi_q, dest_lo_q};
  assign arm_hit    = mthd_valid && hit(mthd_addr, OFS_ARM);
  assign arm_linear = mthd_data[0];
  assign pay_hit    = mthd_valid && hit(mthd_addr, OFS_PAYLOAD);
  assign pay_last   = mthd_last;
  assign pay_word   = mthd_data;

  AST_ONE_METHOD_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    !(arm_hit && pay_hit)); // R2

endmodule

// File: rtl/iue_buffer.sv
module iue_buffer #(
  parameter int WORDS = 256,
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_word,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [31:0]      rd_word
);

  logic [31:0] store [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_idx] <= wr_word;
  end

  assign rd_word = store[rd_idx];

endmodule

// File: rtl/iue_ctrl.sv
module iue_ctrl
  import iue_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int BUF_BYTES = 1024,
  localparam int WORDS    = BUF_BYTES / 4,
  localparam int IDX_W    = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int OFF_W    = $clog2(BUF_BYTES + 1),
  localparam int BEAT_W   = $clog2(WORDS + 1),
  localparam int PROD_W   = 2 * CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] line_len,
  input  logic [CNT_W-1:0] line_cnt,
  input  logic [63:0]      dest_addr,
  input  logic             arm_hit,
  input  logic             arm_linear,
  input  logic             pay_hit,
  input  logic             pay_last,
  output logic             buf_we,
  output logic [IDX_W-1:0] buf_widx,
  output logic [IDX_W-1:0] buf_ridx,
  input  logic [31:0]      buf_rword,
  output logic             mem_wr_valid,
  output logic [63:0]      mem_wr_addr,
  output logic [31:0]      mem_wr_data,
  output logic [3:0]       mem_wr_be,
  output logic             busy,
  output logic             upload_done,
  output logic             err_unsupported,
  output logic             err_overflow
);

  iue_state_e        state;
  logic [OFF_W-1:0]  size_q, fill_q;
  logic [63:0]       dest_q;
  logic [BEAT_W-1:0] beat_q;
  logic              done_q, err_uns_q, err_ovf_q;

  // Named internal events
  logic [PROD_W-1:0] req_size;
  logic              too_big, arm_seen, arm_accept, pay_take, last_take;
  logic [BEAT_W-1:0] n_beats;
  logic              final_beat;
  logic [OFF_W-1:0]  step;

  assign req_size   = PROD_W'(line_len) * PROD_W'(line_cnt);
  assign too_big    = req_size > PROD_W'(BUF_BYTES);
  assign arm_seen   = arm_hit && (state != ST_DRAIN);
  assign arm_accept = arm_seen && arm_linear && !too_big;
  assign pay_take   = pay_hit && (state == ST_ARMED);
  assign last_take  = pay_take && pay_last;
  assign n_beats    = BEAT_W'(beat_count(32'(size_q)));
  assign final_beat = (state == ST_DRAIN) && (beat_q == n_beats - 1'b1);
  assign step       = OFF_W'(step_bytes(32'(size_q), 32'(fill_q)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      size_q    <= '0;
      fill_q    <= '0;
      dest_q    <= '0;
      beat_q    <= '0;
      done_q    <= 1'b0;
      err_uns_q <= 1'b0;
      err_ovf_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (arm_seen) begin
        err_uns_q <= !arm_linear;
        err_ovf_q <= too_big;
        if (arm_accept) begin
          state  <= ST_ARMED;
          size_q <= OFF_W'(req_size);
          fill_q <= '0;
          dest_q <= dest_addr;
        end else begin
          state <= ST_IDLE;
        end
      end else if (pay_take) begin
        fill_q <= fill_q + step;
        if (pay_last) begin
          beat_q <= '0;
          if (n_beats == '0) begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            state <= ST_DRAIN;
          end
        end
      end else if (state == ST_DRAIN) begin
        beat_q <= beat_q + 1'b1;
        if (final_beat) begin
          state  <= ST_IDLE;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign buf_we   = pay_take && (fill_q < size_q);
  assign buf_widx = IDX_W'(fill_q >> 2);
  assign buf_ridx = IDX_W'(beat_q);

  assign mem_wr_valid    = (state == ST_DRAIN);
  assign mem_wr_addr     = dest_q + 64'({beat_q, 2'b00});
  assign mem_wr_data     = buf_rword;
  assign mem_wr_be       = final_beat ? tail_mask(32'(size_q)) : 4'b1111;
  assign busy            = (state != ST_IDLE);
  assign upload_done     = done_q;
  assign err_unsupported = err_uns_q;
  assign err_overflow    = err_ovf_q;

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= size_q); // R4
  AST_DRAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && $past(mem_wr_valid)) |-> (mem_wr_addr == $past(mem_wr_addr) + 64'd4)); // R5
  AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> (mem_wr_be == 4'b0001 || mem_wr_be == 4'b0011 ||
                      mem_wr_be == 4'b0111 || mem_wr_be == 4'b1111)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    upload_done |=> !upload_done); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    upload_done |-> (!busy && !mem_wr_valid)); // R7
  AST_REJECT_TILED: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_seen && !arm_linear) |=> (err_unsupported && !busy)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_seen && arm_linear && too_big) |=> (err_overflow && !busy)); // R9
  AST_IDLE_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_hit && state == ST_IDLE) |=> (!busy && !upload_done)); // R10
  AST_ZERO_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (last_take && size_q == '0) |=> (upload_done && !mem_wr_valid)); // R11

endmodule

// File: rtl/inline_upload_engine.sv
module inline_upload_engine #(
  parameter int MADDR_W   = 12,
  parameter int CNT_W     = 32,
  parameter int BUF_BYTES = 1024
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mthd_valid,
  input  logic [MADDR_W-1:0] mthd_addr,
  input  logic [31:0]        mthd_data,
  input  logic               mthd_last,
  output logic               mem_wr_valid,
  output logic [63:0]        mem_wr_addr,
  output logic [31:0]        mem_wr_data,
  output logic [3:0]         mem_wr_be,
  output logic               busy,
  output logic               upload_done,
  output logic               err_unsupported,
  output logic               err_overflow
);

  localparam int WORDS = BUF_BYTES / 4;
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [CNT_W-1:0] line_len, line_cnt;
  logic [63:0]      dest_addr;
  logic             arm_hit, arm_linear, pay_hit, pay_last;
  logic [31:0]      pay_word, buf_rword;
  logic             buf_we;
  logic [IDX_W-1:0] buf_widx, buf_ridx;

  iue_decode #(.MADDR_W(MADDR_W), .CNT_W(CNT_W)) u_decode (
    .clk(clk), .rst_n(rst_n),
    .mthd_valid(mthd_valid), .mthd_addr(mthd_addr), .mthd_data(mthd_data), .mthd_last(mthd_last),
    .line_len(line_len), .line_cnt(line_cnt), .dest_addr(dest_addr),
    .arm_hit(arm_hit), .arm_linear(arm_linear),
    .pay_hit(pay_hit), .pay_last(pay_last), .pay_word(pay_word)
  );

  iue_buffer #(.WORDS(WORDS)) u_buffer (
    .clk(clk), .wr_en(buf_we), .wr_idx(buf_widx), .wr_word(pay_word),
    .rd_idx(buf_ridx), .rd_word(buf_rword)
  );

  iue_ctrl #(.CNT_W(CNT_W), .BUF_BYTES(BUF_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .line_len(line_len), .line_cnt(line_cnt), .dest_addr(dest_addr),
    .arm_hit(arm_hit), .arm_linear(arm_linear), .pay_hit(pay_hit), .pay_last(pay_last),
    .buf_we(buf_we), .buf_widx(buf_widx), .buf_ridx(buf_ridx), .buf_rword(buf_rword),
    .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_be(mem_wr_be),
    .busy(busy), .upload_done(upload_done),
    .err_unsupported(err_unsupported), .err_overflow(err_overflow)
  );

  AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> busy); // R5

endmodule

// File: tb/inline_upload_engine_test.sv
`timescale 1ns/1ps
module inline_upload_engine_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mthd_valid = 1'b0;
  logic [11:0] mthd_addr = '0;
  logic [31:0] mthd_data = '0;
  logic        mthd_last = 1'b0;
  logic        mem_wr_valid, busy, upload_done, err_unsupported, err_overflow;
  logic [63:0] mem_wr_addr;
  logic [31:0] mem_wr_data;
  logic [3:0]  mem_wr_be;

  inline_upload_engine uut (
    .clk(clk), .rst_n(rst_n),
    .mthd_valid(mthd_valid), .mthd_addr(mthd_addr), .mthd_data(mthd_data), .mthd_last(mthd_last),
    .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_wr_be(mem_wr_be), .busy(busy), .upload_done(upload_done),
    .err_unsupported(err_unsupported), .err_overflow(err_overflow)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 1'b0;

  // Capture of memory beats and completion pulses
  logic [63:0] cap_addr [300];
  logic [31:0] cap_data [300];
  logic [3:0]  cap_be   [300];
  int          cap_cyc  [300];
  int          ncap = 0, done_cnt = 0, done_cyc = 0, last_put_cyc = 0;
  logic [31:0] sent [300];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (mem_wr_valid && ncap < 300) begin
      cap_addr[ncap] = mem_wr_addr;
      cap_data[ncap] = mem_wr_data;
      cap_be[ncap]   = mem_wr_be;
      cap_cyc[ncap]  = cyc;
      ncap++;
    end
    if (upload_done) begin
      done_cnt++;
      done_cyc = cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [11:0] a, input logic [31:0] d, input bit l);
    @(negedge clk);
    mthd_valid = 1'b1; mthd_addr = a; mthd_data = d; mthd_last = l;
    last_put_cyc = cyc;
  endtask

  task automatic quiet();
    @(negedge clk);
    mthd_valid = 1'b0; mthd_last = 1'b0;
  endtask

  task automatic clr();
    ncap = 0; done_cnt = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic setup(input logic [31:0] len, input logic [31:0] cnt, input logic [63:0] dst);
    put(12'h060, len, 0);
    put(12'h061, cnt, 0);
    put(12'h062, dst[63:32], 0);
    put(12'h063, dst[31:0], 0);
  endtask

  // Send nw payload words from sent[], last one flagged, and check the drain.
  task automatic run_and_check(input string req, input int size, input int nw, input logic [63:0] dst);
    int nb, put_c;
    logic [3:0] exp_last;
    for (int i = 0; i < nw; i++) put(12'h06D, sent[i], i == nw - 1);
    put_c = last_put_cyc;
    quiet();
    wait_idle();
    nb = (size + 3) / 4;
    exp_last = (size % 4 == 0) ? 4'hF : 4'((1 << (size % 4)) - 1);
    chk(ncap == nb, req, "beat count", 64'(ncap), 64'(nb));
    for (int i = 0; i < nb && i < ncap; i++) begin
      logic [31:0] m;
      logic [3:0]  eb;
      eb = (i == nb - 1) ? exp_last : 4'hF;
      m  = {{8{eb[3]}}, {8{eb[2]}}, {8{eb[1]}}, {8{eb[0]}}};
      chk(cap_addr[i] == dst + 64'(4 * i), "R5", "beat address", cap_addr[i], dst + 64'(4 * i));
      chk(cap_be[i] == eb, "R6", "byte enables", 64'(cap_be[i]), 64'(eb));
      chk((cap_data[i] & m) == (sent[i] & m), "R4", "beat data", 64'(cap_data[i] & m), 64'(sent[i] & m));
      chk(cap_cyc[i] == put_c + 1 + i, "R5", "beat timing", 64'(cap_cyc[i]), 64'(put_c + 1 + i));
    end
    chk(done_cnt == 1, "R7", "done pulses", 64'(done_cnt), 64'd1);
    if (nb > 0)
      chk(done_cyc == put_c + 1 + nb, "R7", "done timing", 64'(done_cyc), 64'(put_c + 1 + nb));
    chk(!busy, "R7", "busy after done", 64'(busy), 64'd0);
  endtask

  task automatic t_reset();
    chk(!busy && !mem_wr_valid && !upload_done, "R1", "outputs after reset",
        {61'd0, busy, mem_wr_valid, upload_done}, 64'd0);
    chk(!err_unsupported && !err_overflow, "R1", "error flags after reset",
        {62'd0, err_unsupported, err_overflow}, 64'd0);
  endtask

  task automatic t_basic();
    logic [63:0] dst = 64'h0000_0001_0000_1000;
    clr();
    setup(32'd8, 32'd1, dst);
    put(12'h06C, 32'h1, 0);
    quiet();
    chk(busy, "R3", "busy after arm", 64'(busy), 64'd1);
    put(12'h064, 32'hFFFF, 0);        // unmapped offset: no effect (R2)
    quiet();
    chk(busy && !mem_wr_valid, "R2", "unmapped method", 64'(busy), 64'd1);
    sent[0] = 32'h4433_2211; sent[1] = 32'h8877_6655;
    run_and_check("R3", 8, 2, dst);
  endtask

  task automatic t_partial(input int len, input int cnt);
    logic [63:0] dst = 64'hABCD_0000_0000_2000;
    int sz = len * cnt;
    int nw = (sz + 3) / 4;
    clr();
    setup(32'(len), 32'(cnt), dst);
    put(12'h06C, 32'h1, 0);
    for (int i = 0; i < nw; i++) sent[i] = 32'hC0DE_0000 + 32'(i * 32'h0101_0101);
    run_and_check("R6", sz, nw, dst);
  endtask

  task automatic t_excess();
    logic [63:0] dst = 64'h40;
    clr();
    setup(32'd4, 32'd1, dst);
    put(12'h06C, 32'h1, 0);
    put(12'h06D, 32'hAAAA_5555, 0);
    put(12'h06D, 32'h1234_5678, 0);
    put(12'h06D, 32'h9999_9999, 1);
    quiet();
    wait_idle();
    chk(ncap == 1, "R12", "beats with excess payload", 64'(ncap), 64'd1);
    chk(cap_data[0] == 32'hAAAA_5555, "R12", "buffered word kept", 64'(cap_data[0]), 64'hAAAA_5555);
  endtask

  task automatic t_nonlinear();
    clr();
    setup(32'd4, 32'd2, 64'h100);
    put(12'h06C, 32'h0, 0);
    quiet();
    chk(err_unsupported, "R8", "unsupported flag", 64'(err_unsupported), 64'd1);
    chk(!busy, "R8", "busy after tiled arm", 64'(busy), 64'd0);
    put(12'h06D, 32'h1, 0);
    put(12'h06D, 32'h2, 1);
    quiet();
    wait_idle();
    chk(ncap == 0 && done_cnt == 0, "R8", "no write after tiled arm", 64'(ncap + done_cnt), 64'd0);
  endtask

  task automatic t_idle_payload();
    clr();
    put(12'h06D, 32'h77, 0);
    put(12'h06D, 32'h88, 1);
    quiet();
    chk(!busy, "R10", "busy on idle payload", 64'(busy), 64'd0);
    wait_idle();
    chk(ncap == 0 && done_cnt == 0, "R10", "idle payload writes", 64'(ncap + done_cnt), 64'd0);
  endtask

  task automatic t_overflow();
    clr();
    setup(32'd1025, 32'd1, 64'h0);
    put(12'h06C, 32'h1, 0);
    quiet();
    chk(err_overflow && !busy, "R9", "over capacity refused", {62'd0, err_overflow, busy}, 64'd2);
    setup(32'h0001_0000, 32'h0001_0000, 64'h0);
    put(12'h06C, 32'h1, 0);
    quiet();
    chk(err_overflow && !busy, "R9", "wide product refused", {62'd0, err_overflow, busy}, 64'd2);
    put(12'h06D, 32'h5, 1);
    quiet();
    wait_idle();
    chk(ncap == 0 && done_cnt == 0, "R9", "no write after overflow", 64'(ncap + done_cnt), 64'd0);
    // Exactly at capacity
    clr();
    setup(32'd512, 32'd2, 64'h8000);
    put(12'h06C, 32'h1, 0);
    quiet();
    chk(!err_overflow && !err_unsupported && busy, "R9", "capacity accepted",
        {61'd0, err_overflow, err_unsupported, busy}, 64'd1);
    for (int i = 0; i < 256; i++) sent[i] = 32'h5A00_0000 ^ 32'(i * 7919);
    run_and_check("R9", 1024, 256, 64'h8000);
  endtask

  task automatic t_zero();
    clr();
    setup(32'd0, 32'd5, 64'h300);
    put(12'h06C, 32'h1, 0);
    put(12'h06D, 32'h1, 1);
    quiet();
    chk(upload_done && !busy, "R11", "zero size done", {62'd0, upload_done, busy}, 64'd2);
    wait_idle();
    chk(ncap == 0 && done_cnt == 1, "R11", "zero size beats/pulses", {32'(ncap), 32'(done_cnt)}, 64'd1);
  endtask

  task automatic t_rearm();
    logic [63:0] dst = 64'h600;
    clr();
    setup(32'd8, 32'd1, 64'h500);
    put(12'h06C, 32'h1, 0);
    put(12'h06D, 32'hDEAD_DEAD, 0);
    setup(32'd5, 32'd1, dst);
    put(12'h06C, 32'h1, 0);
    sent[0] = 32'h0403_0201; sent[1] = 32'h0000_0005;
    run_and_check("R3", 5, 2, dst);
    // Arm during drain is ignored
    clr();
    setup(32'd12, 32'd1, dst);
    put(12'h06C, 32'h1, 0);
    put(12'h06D, 32'h1, 0);
    put(12'h06D, 32'h2, 0);
    put(12'h06D, 32'h3, 1);
    put(12'h06C, 32'h0, 0);
    quiet();
    wait_idle();
    chk(ncap == 3 && !err_unsupported, "R3", "arm during drain ignored",
        {31'd0, err_unsupported, 32'(ncap)}, 64'd3);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_partial(3, 3);
    t_partial(6, 1);
    t_partial(7, 1);
    t_partial(4, 5);
    t_excess();
    t_nonlinear();
    t_idle_payload();
    t_overflow();
    t_zero();
    t_rearm();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule